// File: doc/BRIEF.md
# Frame Header Length Capture and Threshold Detector

This block sits behind a byte-wide serial target receiver and watches every byte that arrives while chip select is low. It counts the bytes of the current frame from zero and sets a threshold flag as soon as the count reaches a programmed target. Software sets the target to the size of the request header plus four spare bytes. Word-wide reads of the receive buffer then stay aligned, even when the payload is a single byte.

In the same pass, the block takes a multi-byte length field out of the header at a programmed byte index. It stores that field so that software can read how many more bytes of the request still have to be fetched. If chip select is released before the target is reached, a short-frame flag is set instead. Both flags are cleared by writing one to them. The threshold flag drives the interrupt output through a mask bit.

Top module: `hdr_len_capture`

## Requirements
- R1: The byte count is cleared on every falling edge of `cs_n` and then advances by one for each cycle in which `rx_vld` is high and `cs_n` is low. A byte presented in the same cycle that `cs_n` falls is the first byte of the frame, so the count reads 1 afterwards. The count saturates at its maximum value.
- R2: While `cs_n` is high, `rx_vld` has no effect: the count, the captured length and the flags do not change.
- R3: `hit_flag` goes high in the cycle after the accepted byte that brings the frame's count equal to the target value. It stays low for all earlier bytes.
- R4: The threshold event happens at most once per frame. After the flag has been cleared, later bytes of the same frame do not set it again.
- R5: `irq` is high exactly when `hit_flag` is high and the mask bit is 0. The mask is bit 0 of address 4, where 1 masks, and it resets to 1.
- R6: A write to address 5 with data bit 0 set clears `hit_flag`. If that write falls in the same cycle as a threshold event, the flag stays set.
- R7: `cap_len` is cleared at frame start. The byte at index `offset` goes into `cap_len[7:0]` and the byte at index `offset+1` goes into `cap_len[15:8]`, where indices count from 0 at the first byte of the frame.
- R8: `cap_len` and `byte_cnt` hold their values after `cs_n` rises, until the next frame starts.
- R9: If `cs_n` rises and the current frame has had no threshold event, `short_flag` is set and `hit_flag` is left unchanged. A write to address 5 with data bit 1 set clears `short_flag`.
- R10: The target is written one byte at a time, with the low byte at address 0 and the high byte at address 1. The offset is written the same way, with the low byte at address 2 and the high byte at address 3. The full 16-bit values take part in the comparisons.
- R11: After reset, the count, the captured length and both flags are 0, `irq` is 0, the target is 12 and the offset is 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; a falling edge starts a frame |
| rx_vld | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte value |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address (0..5) |
| cfg_wdata | input | 8 | Register write data |
| irq | output | 1 | Threshold interrupt (flag and not masked) |
| hit_flag | output | 1 | Threshold-reached flag, write-one-to-clear |
| short_flag | output | 1 | Frame ended before the threshold, write-one-to-clear |
| cap_len | output | 16 | Captured little-endian length field |
| byte_cnt | output | 16 | Bytes accepted in the current or last frame |

## Verification
The first frame runs on the reset configuration. It starts with a byte in the same cycle as the chip-select edge, which separates a counter that restarts correctly from one that drops or double-counts that first byte. Further frames follow with a short target at a small offset, then a target and an offset whose high bytes are nonzero. The second case exposes designs that compare only the low byte of either value. A frame that ends early tells the short-frame path apart from the threshold path. A clear write that lands on the threshold byte shows which side wins the flag update. Bytes strobed while chip select is high, and bytes sent after a mid-frame clear, confirm that the captured state stays put and that the event does not fire twice.

// File: rtl/hlc_pkg.sv
package hlc_pkg;
  // Register map; the indices are fixed by the address decode.
  typedef enum logic [2:0] {
    REG_TGT_LO  = 3'd0,
    REG_TGT_HI  = 3'd1,
    REG_OFF_LO  = 3'd2,
    REG_OFF_HI  = 3'd3,
    REG_MASK    = 3'd4,
    REG_STATUS  = 3'd5
  } hlc_reg_e;

  // Bit positions inside the status register.
  localparam int unsigned ST_HIT_BIT   = 0;
  localparam int unsigned ST_SHORT_BIT = 1;
endpackage

// File: rtl/hlc_cfg_regs.sv
module hlc_cfg_regs #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned RST_TARGET = 12,
  parameter int unsigned RST_OFFSET = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  target,
  output logic [CNT_W-1:0]  offset,
  output logic              irq_mask,
  output logic              clr_hit,
  output logic              clr_short
);
  import hlc_pkg::*;

  localparam int unsigned NB = CNT_W / DATA_W;
  localparam logic [CNT_W-1:0] TGT_INIT = CNT_W'(RST_TARGET);
  localparam logic [CNT_W-1:0] OFF_INIT = CNT_W'(RST_OFFSET);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STATUS);

  // One write strobe per byte lane of each multi-byte value.
  function automatic logic lane_sel(input logic [ADDR_W-1:0] a, input int unsigned base,
                                    input int unsigned k);
    return a == ADDR_W'(base + k);
  endfunction

  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        target[k*DATA_W +: DATA_W] <= TGT_INIT[k*DATA_W +: DATA_W];
        offset[k*DATA_W +: DATA_W] <= OFF_INIT[k*DATA_W +: DATA_W];
      end else if (cfg_we) begin
        if (lane_sel(cfg_addr, 0, k))
          target[k*DATA_W +: DATA_W] <= cfg_wdata;
        if (lane_sel(cfg_addr, NB, k))
          offset[k*DATA_W +: DATA_W] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          irq_mask <= 1'b1;
    else if (cfg_we && cfg_addr == A_MASK) irq_mask <= cfg_wdata[0];
  end

  assign clr_hit   = cfg_we && (cfg_addr == A_STAT) && cfg_wdata[ST_HIT_BIT];
  assign clr_short = cfg_we && (cfg_addr == A_STAT) && cfg_wdata[ST_SHORT_BIT];
endmodule

// File: rtl/hlc_frame_ctr.sv
module hlc_frame_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rx_vld,
  output logic             frame_start,
  output logic             frame_end,
  output logic             byte_take,
  output logic [CNT_W-1:0] cur_idx,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [CNT_W-1:0] cnt
);
  logic cs_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign frame_start = cs_q & ~cs_n;
  assign frame_end   = ~cs_q & cs_n;
  assign byte_take   = ~cs_n & rx_vld;
  // Index of the byte on the bus this cycle (a frame-start byte is index 0).
  assign cur_idx     = frame_start ? '0 : cnt;
  assign nxt_cnt     = sat_inc(cur_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (byte_take)  cnt <= nxt_cnt;
    else if (frame_start) cnt <= '0;
  end
endmodule

// File: rtl/hlc_len_latch.sv
module hlc_len_latch #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LEN_BYTES = 2,
  localparam int unsigned LEN_W    = DATA_W * LEN_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_take,
  input  logic [CNT_W-1:0]  cur_idx,
  input  logic [CNT_W-1:0]  offset,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [LEN_W-1:0]  cap_len
);
  // Lane k takes the byte at offset+k; one extra bit keeps offset+k from wrapping.
  function automatic logic lane_hit(input logic [CNT_W-1:0] idx, input logic [CNT_W-1:0] off,
                                    input int unsigned k);
    return {1'b0, idx} == ({1'b0, off} + (CNT_W+1)'(k));
  endfunction

  for (genvar k = 0; k < LEN_BYTES; k++) begin : g_lane
    logic take_here;
    assign take_here = byte_take && lane_hit(cur_idx, offset, k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cap_len[k*DATA_W +: DATA_W] <= '0;
      else if (take_here)   cap_len[k*DATA_W +: DATA_W] <= rx_byte;
      else if (frame_start) cap_len[k*DATA_W +: DATA_W] <= '0;
    end
  end
endmodule

// File: rtl/hlc_flags.sv
module hlc_flags #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             byte_take,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic [CNT_W-1:0] target,
  input  logic             clr_hit,
  input  logic             clr_short,
  output logic             hit_ev,
  output logic             short_ev,
  output logic             hit_flag,
  output logic             short_flag
);
  logic fired;
  logic fired_eff;

  function automatic logic reaches(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c == t;
  endfunction

  // A new frame forgets the previous frame's event.
  assign fired_eff = fired & ~frame_start;
  assign hit_ev    = byte_take & reaches(nxt_cnt, target) & ~fired_eff;
  assign short_ev  = frame_end & ~fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired <= 1'b0;
    else        fired <= fired_eff | hit_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hit_flag <= 1'b0;
    else if (hit_ev)  hit_flag <= 1'b1;
    else if (clr_hit) hit_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         short_flag <= 1'b0;
    else if (short_ev)  short_flag <= 1'b1;
    else if (clr_short) short_flag <= 1'b0;
  end
endmodule

// File: rtl/hdr_len_capture.sv
module hdr_len_capture #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned LEN_BYTES  = 2,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned RST_TARGET = 12,
  parameter int unsigned RST_OFFSET = 6,
  localparam int unsigned LEN_W     = DATA_W * LEN_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_vld,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              irq,
  output logic              hit_flag,
  output logic              short_flag,
  output logic [LEN_W-1:0]  cap_len,
  output logic [CNT_W-1:0]  byte_cnt
);
  // Named internal events, observed by the bound checker.
  logic             frame_start;
  logic             frame_end;
  logic             byte_take;
  logic             hit_ev;
  logic             short_ev;
  logic [CNT_W-1:0] cur_idx;
  logic [CNT_W-1:0] nxt_cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] offset;
  logic             irq_mask;
  logic             clr_hit;
  logic             clr_short;

  hlc_cfg_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .RST_TARGET(RST_TARGET), .RST_OFFSET(RST_OFFSET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .target(target), .offset(offset), .irq_mask(irq_mask),
    .clr_hit(clr_hit), .clr_short(clr_short)
  );

  hlc_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld),
    .frame_start(frame_start), .frame_end(frame_end), .byte_take(byte_take),
    .cur_idx(cur_idx), .nxt_cnt(nxt_cnt), .cnt(byte_cnt)
  );

  hlc_len_latch #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_BYTES(LEN_BYTES)) u_len (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_take(byte_take),
    .cur_idx(cur_idx), .offset(offset), .rx_byte(rx_byte), .cap_len(cap_len)
  );

  hlc_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .byte_take(byte_take), .nxt_cnt(nxt_cnt), .target(target),
    .clr_hit(clr_hit), .clr_short(clr_short),
    .hit_ev(hit_ev), .short_ev(short_ev), .hit_flag(hit_flag), .short_flag(short_flag)
  );

  assign irq = hit_flag & ~irq_mask;
endmodule

// File: rtl/hlc_checker.sv
module hlc_checker #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STAT_ADDR = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              wr_bit0,
  input logic              frame_start,
  input logic              byte_take,
  input logic              hit_ev,
  input logic              short_ev,
  input logic              irq,
  input logic              hit_flag,
  input logic              short_flag,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [LEN_W-1:0]  cap_len
);
  // Checker-side record of whether this frame already had its event.
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen <= 1'b0;
    else if (frame_start) seen <= hit_ev;
    else if (hit_ev)      seen <= 1'b1;
  end

  p_start_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && byte_take) |=> byte_cnt == CNT_W'(1));
  p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !byte_take) |=> byte_cnt == '0);
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && !frame_start && byte_cnt != '1) |=> byte_cnt == $past(byte_cnt) + CNT_W'(1));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(byte_cnt) && $stable(cap_len)));
  p_idle_no_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !hit_ev);
  p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> hit_flag);
  p_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |-> !(seen && !frame_start));
  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hit_flag);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && !hit_ev && cfg_we && cfg_addr == ADDR_W'(STAT_ADDR) && wr_bit0) |=> !hit_flag);
  p_short_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_ev |-> !hit_ev);
  p_short_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_ev |=> short_flag);
endmodule

bind hdr_len_capture hlc_checker #(
  .CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .STAT_ADDR(5)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .wr_bit0(cfg_wdata[0]), .frame_start(frame_start), .byte_take(byte_take),
  .hit_ev(hit_ev), .short_ev(short_ev), .irq(irq), .hit_flag(hit_flag),
  .short_flag(short_flag), .byte_cnt(byte_cnt), .cap_len(cap_len)
);

// File: tb/sim_hdr_len_capture.sv
module sim_hdr_len_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rx_vld, cfg_we;
  logic [7:0]  rx_byte, cfg_wdata;
  logic [2:0]  cfg_addr;
  logic        irq, hit_flag, short_flag;
  logic [15:0] cap_len, byte_cnt;

  always #10 clk = ~clk;

  hdr_len_capture u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq(irq), .hit_flag(hit_flag), .short_flag(short_flag),
    .cap_len(cap_len), .byte_cnt(byte_cnt)
  );

  typedef struct {
    string       tag;
    logic [15:0] cnt;
    logic [15:0] len;
    logic        hit;
    logic        shrt;
    logic        irq;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  exp_t cur;

  // Monitor: compares one queued expectation per falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      total++;
      if (byte_cnt !== cur.cnt || cap_len !== cur.len || hit_flag !== cur.hit ||
          short_flag !== cur.shrt || irq !== cur.irq) begin
        bad++;
        $display("FAIL %s: cnt=%h len=%h hit=%b short=%b irq=%b expected cnt=%h len=%h hit=%b short=%b irq=%b",
                 cur.tag, byte_cnt, cap_len, hit_flag, short_flag, irq,
                 cur.cnt, cur.len, cur.hit, cur.shrt, cur.irq);
      end
    end
  end

  task automatic cyc(input logic cs, input logic v, input logic [7:0] d,
                     input logic we, input logic [2:0] a, input logic [7:0] wd);
    @(negedge clk);
    cs_n = cs; rx_vld = v; rx_byte = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    @(posedge clk);
  endtask

  task automatic sendb(input logic [7:0] d);  cyc(1'b0, 1'b1, d, 1'b0, 3'd0, 8'd0); endtask
  task automatic idle(input logic cs);        cyc(cs, 1'b0, 8'd0, 1'b0, 3'd0, 8'd0); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); cyc(cs_n, 1'b0, 8'd0, 1'b1, a, d); endtask

  task automatic expect_st(input string tag, input logic [15:0] c, input logic [15:0] l,
                           input logic h, input logic s, input logic i);
    exp_t e;
    e.tag = tag; e.cnt = c; e.len = l; e.hit = h; e.shrt = s; e.irq = i;
    q.push_back(e);
  endtask

  function automatic logic [7:0] pat_e(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rx_vld = 1'b0; rx_byte = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(1'b1);
    expect_st("R11 reset state", 16'd0, 16'h0000, 0, 0, 0);

    // Frame A on reset config (target 12, offset 6); first byte on the cs edge.
    sendb(8'h10);
    expect_st("R1 byte on frame edge counts", 16'd1, 16'h0000, 0, 0, 0);
    for (int i = 1; i <= 10; i++) sendb(8'(8'h10 + i));
    expect_st("R3 one below target", 16'd11, 16'h1716, 0, 0, 0);
    sendb(8'h1B);
    expect_st("R11 R7 R5 default target hit, masked", 16'd12, 16'h1716, 1, 0, 0);
    wr(3'd4, 8'h00);
    expect_st("R5 unmasked irq", 16'd12, 16'h1716, 1, 0, 1);
    wr(3'd5, 8'h01);
    expect_st("R6 write-one clears", 16'd12, 16'h1716, 0, 0, 0);
    sendb(8'h1C); sendb(8'h1D);
    expect_st("R4 no second event", 16'd14, 16'h1716, 0, 0, 0);
    idle(1'b1);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 8'hEE, 1'b0, 3'd0, 8'd0);
    expect_st("R2 R8 strobes with cs high ignored", 16'd14, 16'h1716, 0, 0, 0);

    // New target 10, offset 3.
    wr(3'd0, 8'd10); wr(3'd1, 8'd0); wr(3'd2, 8'd3); wr(3'd3, 8'd0);
    idle(1'b0);
    expect_st("R1 R7 restart clears", 16'd0, 16'h0000, 0, 0, 0);
    for (int i = 0; i < 9; i++) sendb(8'(8'h40 + i));
    expect_st("R10 before new target", 16'd9, 16'h4443, 0, 0, 0);
    sendb(8'h49);
    expect_st("R10 new target hit", 16'd10, 16'h4443, 1, 0, 1);
    idle(1'b1);

    // Set wins over a same-cycle clear.
    wr(3'd5, 8'h01);
    expect_st("R6 clear between frames", 16'd10, 16'h4443, 0, 0, 0);
    idle(1'b0);
    for (int i = 0; i < 9; i++) sendb(8'(8'h60 + i));
    cyc(1'b0, 1'b1, 8'h69, 1'b1, 3'd5, 8'h01);
    expect_st("R6 set wins over clear", 16'd10, 16'h6463, 1, 0, 1);
    idle(1'b1);

    // Short frame.
    wr(3'd5, 8'h01);
    idle(1'b0);
    for (int i = 0; i < 5; i++) sendb(8'(8'h80 + i));
    idle(1'b1);
    expect_st("R9 short frame flagged", 16'd5, 16'h8483, 0, 1, 0);
    wr(3'd5, 8'h02);
    expect_st("R9 short flag cleared", 16'd5, 16'h8483, 0, 0, 0);

    // High bytes matter: target 261, offset 258.
    wr(3'd0, 8'h05); wr(3'd1, 8'h01); wr(3'd2, 8'h02); wr(3'd3, 8'h01);
    idle(1'b0);
    for (int i = 0; i < 260; i++) sendb(pat_e(i));
    expect_st("R10 high byte of target respected", 16'd260, {pat_e(259), pat_e(258)}, 0, 0, 0);
    sendb(pat_e(260));
    expect_st("R10 wide target hit", 16'd261, {pat_e(259), pat_e(258)}, 1, 0, 1);
    sendb(pat_e(261));
    expect_st("R7 wide offset capture", 16'd262, {pat_e(259), pat_e(258)}, 1, 0, 1);
    wr(3'd4, 8'h01);
    expect_st("R5 re-masked", 16'd262, {pat_e(259), pat_e(258)}, 1, 0, 0);
    idle(1'b1);

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule